// File: doc/BRIEF.md
# Signed-Digit Tree Array Multiplier

This block multiplies two 8-digit radix-2 signed-digit operands and returns the product as signed digits. It is purely combinational. Every digit takes one of the values -1, 0 or +1 and is carried on three wires, with exactly one wire high.

The multiplier works in two stages:

- **Partial products.** Each digit of X is multiplied by every digit of Y using a sign rule, so no binary arithmetic is needed. Row i is then shifted up by i places.
- **Reduction.** The eight rows are summed pairwise in a balanced tree of carry-free signed-digit adders. The first level has four adders, the second level two, and the third level one.

Every adder first pads its addends with explicit zero digits to a common width. These padded positions still pass through adder cells, because adding a zero can recode a digit and emit a carry. Each level therefore grows the sum by one digit. The product leaves the block 18 digits wide, which is enough to hold every result exactly.

A separate flag reports any operand digit whose three wires are not a legal one-hot code. While that flag is set, the product carries no meaning.

Top module: `sd_tree_mult`

## Requirements
- R1: A digit occupies bits [3k+2:3k] for digit k, with k = 0 the least significant. The code 100 means -1, 010 means 0 and 001 means +1. An operand's value is the sum of digit k times 2^k.
- R2: For every pair of valid operands, the value of `product_o` equals the integer product of the values of `x_i` and `y_i`.
- R3: `product_o` has 18 digits, and every one of them is a legal code (100, 010 or 001) whenever `invalid_o` is low.
- R4: `invalid_o` is 1 exactly when at least one digit of `x_i` or `y_i` is a pattern other than 100, 010 or 001.
- R5: The extreme operands give exact results: all digits +1 times all digits +1 gives 65025, all -1 times all -1 gives 65025, and all +1 times all -1 gives -65025.
- R6: Different redundant digit strings for the same operand value produce products with the same value.
- R7: The product of a single nonzero digit of X at position i and a single nonzero digit of Y at position j has value s·2^(i+j). Here s is +1 when the two digits have the same sign and -1 when their signs differ.
- R8: An operand whose digits are all zero (010) gives a product of value 0, whatever the other operand holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 24 | Multiplicand, eight one-hot signed digits |
| y_i | input | 24 | Multiplier, eight one-hot signed digits |
| product_o | output | 54 | Product, eighteen one-hot signed digits |
| invalid_o | output | 1 | High when any operand digit is not a legal code |

## Verification
The hardest condition to reach from the ports is a carry that has to cross into the zero-padded upper positions of every tree level, so that the two top product digits become nonzero. Random operands rarely drive every row at full magnitude at once.

The stimulus forces this case directly with all-+1 and all-negative operands and their mixed-sign pairing. It then adds redundant forms that differ only in how the value is spread across digits. Those forms make the same value travel through different adder-cell paths, and the results must still agree.

// File: rtl/sd_pkg.sv
// Package: signed-digit code values and helpers shared by the multiplier.
// Assumes a digit is three wires with exactly one set when legal.
package sd_pkg;

    typedef logic [2:0] sdigit_t;

    localparam sdigit_t SD_NEG  = 3'b100;
    localparam sdigit_t SD_ZERO = 3'b010;
    localparam sdigit_t SD_POS  = 3'b001;

    // Integer value of a digit; illegal codes read as zero.
    function automatic int sd_val(input sdigit_t d);
        case (d)
            SD_POS:  return 1;
            SD_NEG:  return -1;
            default: return 0;
        endcase
    endfunction

    // Code for an integer in the range -1..1.
    function automatic sdigit_t sd_enc(input int v);
        if (v > 0)      return SD_POS;
        else if (v < 0) return SD_NEG;
        else            return SD_ZERO;
    endfunction

    // True when the digit is one of the three legal codes.
    function automatic logic sd_ok(input sdigit_t d);
        return (d == SD_NEG) || (d == SD_ZERO) || (d == SD_POS);
    endfunction

endpackage

// File: rtl/sd_digit_mul.sv
// Module: sd_digit_mul
// Multiplies two signed digits using the sign rule.
// Either zero gives zero, equal signs give +1, and opposite signs give -1.
// Assumes legal codes on the inputs; illegal codes give an unspecified output.
module sd_digit_mul
    import sd_pkg::*;
(
    input  logic [2:0] a_i,
    input  logic [2:0] b_i,
    output logic [2:0] p_o
);

    // Form the one-hot product directly from the code wires.
    always_comb begin
        p_o[0] = (a_i[0] & b_i[0]) | (a_i[2] & b_i[2]);
        p_o[1] = a_i[1] | b_i[1];
        p_o[2] = (a_i[0] & b_i[2]) | (a_i[2] & b_i[0]);
    end

    // Guard: the product digit matches the arithmetic product of its inputs.
    always_comb begin
        if (sd_ok(a_i) && sd_ok(b_i)) begin
            assert_digit_prod_R7: assert (sd_val(p_o) == sd_val(a_i) * sd_val(b_i) && sd_ok(p_o))
                else $error("digit product mismatch");
            assert_digit_zero_R8: assert (!(a_i == SD_ZERO || b_i == SD_ZERO) || p_o == SD_ZERO)
                else $error("zero digit did not yield zero");
        end
    end

endmodule

// File: rtl/sd_add_cell.sv
// Module: sd_add_cell
// One carry-free signed-digit adder position.
// It splits x+y into an interim digit and a carry, using the sign of the pair one place
// below to pick the split, then adds the carry arriving from below.
// Assumes the digits below are zero at position 0.
module sd_add_cell
    import sd_pkg::*;
(
    input  logic [2:0] x_i,
    input  logic [2:0] y_i,
    input  logic [2:0] xlo_i,
    input  logic [2:0] ylo_i,
    input  logic [2:0] cin_i,
    output logic [2:0] c_o,
    output logic [2:0] s_o
);

    int  pair_sum;
    int  interim;
    int  carry;
    logic low_neg;

    // Split the digit pair into an interim digit and an outgoing carry.
    always_comb begin
        pair_sum = sd_val(x_i) + sd_val(y_i);
        low_neg  = (xlo_i == SD_NEG) || (ylo_i == SD_NEG);
        interim  = 0;
        carry    = 0;
        case (pair_sum)
            -2: begin interim = 0;  carry = -1; end
            -1: begin
                if (low_neg) begin interim = 1;  carry = -1; end
                else         begin interim = -1; carry = 0;  end
            end
            1: begin
                if (low_neg) begin interim = 1;  carry = 0; end
                else         begin interim = -1; carry = 1; end
            end
            2: begin interim = 0;  carry = 1; end
            default: begin interim = 0; carry = 0; end
        endcase
        c_o = sd_enc(carry);
        s_o = sd_enc(interim + sd_val(cin_i));
    end

    // Guard: the final digit and the carry stay legal codes when inputs are legal.
    always_comb begin
        if (sd_ok(x_i) && sd_ok(y_i) && sd_ok(xlo_i) && sd_ok(ylo_i) && sd_ok(cin_i)) begin
            assert_cell_code_R3: assert (interim + sd_val(cin_i) >= -1 && interim + sd_val(cin_i) <= 1)
                else $error("cell sum out of digit range");
        end
    end

endmodule

// File: rtl/sd_adder.sv
// Module: sd_adder
// Carry-free adder for two N_DIG-digit signed-digit numbers.
// The result has N_DIG+1 digits. The top position adds explicit zero digits and
// absorbs the last carry. Delay does not depend on N_DIG.
module sd_adder
    import sd_pkg::*;
#(
    parameter int N_DIG = 8,
    localparam int OUT_DIG = N_DIG + 1
) (
    input  logic [3*N_DIG-1:0]   a_i,
    input  logic [3*N_DIG-1:0]   b_i,
    output logic [3*OUT_DIG-1:0] sum_o
);

    for (genvar p = 0; p < OUT_DIG; p++) begin : pos
        logic [2:0] xa, ya, xl, yl, ci, c, s;

        // Pad the operands with zero digits above the top position.
        if (p < N_DIG) begin : g_in
            assign xa = a_i[3*p +: 3];
            assign ya = b_i[3*p +: 3];
        end else begin : g_pad
            assign xa = SD_ZERO;
            assign ya = SD_ZERO;
        end

        // Digits and carry from the position below; zero at the bottom.
        if (p == 0) begin : g_low0
            assign xl = SD_ZERO;
            assign yl = SD_ZERO;
            assign ci = SD_ZERO;
        end else begin : g_low
            assign xl = a_i[3*(p-1) +: 3];
            assign yl = b_i[3*(p-1) +: 3];
            assign ci = pos[p-1].c;
        end

        sd_add_cell u_cell (
            .x_i  (xa),
            .y_i  (ya),
            .xlo_i(xl),
            .ylo_i(yl),
            .cin_i(ci),
            .c_o  (c),
            .s_o  (s)
        );

        assign sum_o[3*p +: 3] = s;
    end

    // Guard: the sum keeps the exact value of the two addends.
    always_comb begin
        int va, vb, vs;
        logic legal;
        va = 0; vb = 0; vs = 0; legal = 1'b1;
        for (int k = 0; k < N_DIG; k++) begin
            va += sd_val(a_i[3*k +: 3]) * (1 << k);
            vb += sd_val(b_i[3*k +: 3]) * (1 << k);
            legal &= sd_ok(a_i[3*k +: 3]) & sd_ok(b_i[3*k +: 3]);
        end
        for (int k = 0; k < OUT_DIG; k++) begin
            vs += sd_val(sum_o[3*k +: 3]) * (1 << k);
        end
        if (legal) begin
            assert_adder_value_R2: assert (vs == va + vb)
                else $error("adder value mismatch");
        end
    end

endmodule

// File: rtl/sd_code_check.sv
// Module: sd_code_check
// Reports whether any digit of a signed-digit word is not a legal one-hot code.
module sd_code_check
    import sd_pkg::*;
#(
    parameter int N_DIG = 8
) (
    input  logic [3*N_DIG-1:0] digits_i,
    output logic               bad_o
);

    // Scan all digits for a code outside the legal set.
    always_comb begin
        bad_o = 1'b0;
        for (int k = 0; k < N_DIG; k++) begin
            if (!sd_ok(digits_i[3*k +: 3])) bad_o = 1'b1;
        end
    end

endmodule

// File: rtl/sd_tree_mult.sv
// Module: sd_tree_mult
// Combinational signed-digit array multiplier.
// Partial-product rows are formed by the digit sign rule and reduced pairwise in a
// balanced tree of carry-free adders.
// Assumes N_DIG is a power of two; the product has 2*N_DIG-1+log2(N_DIG) digits.
module sd_tree_mult
    import sd_pkg::*;
#(
    parameter int N_DIG = 8,
    localparam int LVLS  = $clog2(N_DIG),
    localparam int PP_W  = 2 * N_DIG - 1,
    localparam int OUT_W = PP_W + LVLS
) (
    input  logic [3*N_DIG-1:0] x_i,
    input  logic [3*N_DIG-1:0] y_i,
    output logic [3*OUT_W-1:0] product_o,
    output logic               invalid_o
);

    logic bad_x, bad_y;

    sd_code_check #(.N_DIG(N_DIG)) u_chk_x (.digits_i(x_i), .bad_o(bad_x));
    sd_code_check #(.N_DIG(N_DIG)) u_chk_y (.digits_i(y_i), .bad_o(bad_y));

    // Flag any illegal digit on either operand.
    assign invalid_o = bad_x | bad_y;

    // Partial-product rows: row i is x digit i times Y, shifted up by i.
    for (genvar i = 0; i < N_DIG; i++) begin : row
        logic [3*PP_W-1:0] pp;

        for (genvar j = 0; j < N_DIG; j++) begin : col
            logic [2:0] d;
            sd_digit_mul u_mul (
                .a_i(x_i[3*i +: 3]),
                .b_i(y_i[3*j +: 3]),
                .p_o(d)
            );
        end

        for (genvar p = 0; p < PP_W; p++) begin : place
            if (p >= i && p - i < N_DIG) begin : g_dig
                assign pp[3*p +: 3] = col[p-i].d;
            end else begin : g_pad
                assign pp[3*p +: 3] = SD_ZERO;
            end
        end
    end

    // Reduction tree: level l holds N_DIG>>l values of PP_W+l digits.
    for (genvar l = 0; l <= LVLS; l++) begin : lvl
        localparam int CNT = N_DIG >> l;
        localparam int W   = PP_W + l;
        for (genvar m = 0; m < CNT; m++) begin : nd
            logic [3*W-1:0] v;
            if (l == 0) begin : g_leaf
                assign v = row[m].pp;
            end else begin : g_add
                sd_adder #(.N_DIG(W-1)) u_add (
                    .a_i  (lvl[l-1].nd[2*m].v),
                    .b_i  (lvl[l-1].nd[2*m+1].v),
                    .sum_o(v)
                );
            end
        end
    end

    assign product_o = lvl[LVLS].nd[0].v;

    // Guard: with legal operands every product digit is a legal code.
    always_comb begin
        if (!invalid_o) begin
            for (int k = 0; k < OUT_W; k++) begin
                assert_product_code_R3: assert (sd_ok(product_o[3*k +: 3]))
                    else $error("illegal product digit %0d", k);
            end
        end
    end

endmodule

// File: tb/sd_tree_mult_tb_top.sv
`timescale 1ns/1ps
// Bench: drives operands after each rising edge and checks at the falling edge.
// Results are checked against integer arithmetic on the digit values.
module sd_tree_mult_tb_top;

    localparam int N  = 8;
    localparam int OW = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3*N-1:0]  x, y;
    logic [3*OW-1:0] prod;
    logic            inv;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sd_tree_mult #(.N_DIG(N)) dut_i (
        .x_i      (x),
        .y_i      (y),
        .product_o(prod),
        .invalid_o(inv)
    );

    // Build a digit word from +1 and -1 position masks (R1 encoding).
    function automatic logic [3*N-1:0] from_masks(input logic [7:0] pm, input logic [7:0] nm);
        logic [3*N-1:0] w;
        for (int k = 0; k < N; k++) begin
            if (pm[k])      w[3*k +: 3] = 3'b001;
            else if (nm[k]) w[3*k +: 3] = 3'b100;
            else            w[3*k +: 3] = 3'b010;
        end
        return w;
    endfunction

    // Value of the product digits per the R1 code.
    function automatic int decode(input logic [3*OW-1:0] w);
        int v = 0;
        for (int k = 0; k < OW; k++) begin
            if (w[3*k +: 3] == 3'b001)      v += (1 << k);
            else if (w[3*k +: 3] == 3'b100) v -= (1 << k);
        end
        return v;
    endfunction

    function automatic bit all_legal(input logic [3*OW-1:0] w);
        for (int k = 0; k < OW; k++) begin
            if (w[3*k +: 3] != 3'b001 && w[3*k +: 3] != 3'b010 && w[3*k +: 3] != 3'b100) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply valid operands and check value, codes and the flag; returns the value seen.
    task automatic run(input logic [7:0] xp, input logic [7:0] xn,
                       input logic [7:0] yp, input logic [7:0] yn,
                       input string req, output int got);
        int ex;
        @(posedge clk); #1;
        x = from_masks(xp, xn);
        y = from_masks(yp, yn);
        @(negedge clk);
        ex  = (int'(xp) - int'(xn)) * (int'(yp) - int'(yn));
        got = decode(prod);
        chk(got == ex, req, got, ex);
        chk(all_legal(prod), "R3", int'(all_legal(prod)), 1);
        chk(inv == 1'b0, "R4", int'(inv), 0);
    endtask

    task automatic run_raw(input logic [3*N-1:0] xv, input logic [3*N-1:0] yv,
                           input logic exp_inv, input string req);
        @(posedge clk); #1;
        x = xv;
        y = yv;
        @(negedge clk);
        chk(inv == exp_inv, req, int'(inv), int'(exp_inv));
    endtask

    initial begin
        int g, g1, g2, g3;
        logic [7:0] rp, rn, sp, sn;
        x = '0;
        y = '0;
        // Reset phase: all-000 operands are illegal codes (R4).
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(inv == 1'b1, "R4 reset", int'(inv), 1);
        rst_n = 1'b1;

        // R5 extreme operands.
        run(8'hFF, 8'h00, 8'hFF, 8'h00, "R5 +all*+all", g);
        run(8'h00, 8'hFF, 8'h00, 8'hFF, "R5 -all*-all", g);
        run(8'hFF, 8'h00, 8'h00, 8'hFF, "R5 +all*-all", g);
        run(8'h0F, 8'h00, 8'h0F, 8'h00, "R2 15*15", g);

        // R8 zero operand on either side.
        run(8'h00, 8'h00, 8'hA5, 8'h42, "R8 zero x", g);
        run(8'h3C, 8'hC0, 8'h00, 8'h00, "R8 zero y", g);

        // R7 single-digit pairs with all four sign combinations.
        for (int i = 0; i < N; i += 3) begin
            for (int j = 0; j < N; j += 2) begin
                run(8'(1 << i), 8'h00, 8'(1 << j), 8'h00, "R7 ++", g);
                run(8'(1 << i), 8'h00, 8'h00, 8'(1 << j), "R7 +-", g);
                run(8'h00, 8'(1 << i), 8'(1 << j), 8'h00, "R7 -+", g);
                run(8'h00, 8'(1 << i), 8'h00, 8'(1 << j), "R7 --", g);
            end
        end

        // R6 redundant forms of 6 and of 15 give equal products.
        run(8'b0000_0110, 8'b0000_0000, 8'h5B, 8'h24, "R6 6 form a", g1);
        run(8'b0000_1010, 8'b0000_0100, 8'h5B, 8'h24, "R6 6 form b", g2);
        run(8'b0000_1000, 8'b0000_0010, 8'h5B, 8'h24, "R6 6 form c", g3);
        chk(g1 == g2 && g2 == g3, "R6 six", g2, g1);
        run(8'b0000_1111, 8'h00, 8'hFF, 8'h00, "R6 15 form a", g1);
        run(8'b0001_0000, 8'b0000_0001, 8'hFF, 8'h00, "R6 15 form b", g2);
        chk(g1 == g2, "R6 fifteen", g2, g1);

        // R4 illegal codes at several positions on each operand.
        run_raw(from_masks(8'h12, 8'h40), from_masks(8'h01, 8'h00), 1'b0, "R4 legal");
        for (int k = 0; k < N; k += 3) begin
            logic [3*N-1:0] bad;
            bad = from_masks(8'h0F, 8'hF0);
            bad[3*k +: 3] = 3'b011;
            run_raw(bad, from_masks(8'h01, 8'h00), 1'b1, "R4 x 011");
            bad[3*k +: 3] = 3'b000;
            run_raw(from_masks(8'h01, 8'h00), bad, 1'b1, "R4 y 000");
            bad[3*k +: 3] = 3'b111;
            run_raw(bad, bad, 1'b1, "R4 both 111");
        end

        // R2 random valid operands in redundant form.
        for (int t = 0; t < 400; t++) begin
            rp = 8'($urandom);
            rn = 8'($urandom) & ~rp;
            sp = 8'($urandom);
            sn = 8'($urandom) & ~sp;
            run(rp, rn, sp, sn, "R2 random", g);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule